// File: doc/BRIEF.md
# Program-Entry and Monitor Front End for a Tape-Machine Interpreter

This block is the operator side of a small eight-opcode tape-machine interpreter. A mode input picks between entering a program and running it. While entering, a 6-bit address field and a 3-bit opcode field come from switches. Each press of an active-low push-button stores the opcode at the addressed slot of a 64-word command store. Three LEDs always show the word held at the addressed slot.

In run mode the execution core reads the command store and a 32-cell, 8-bit data store through its own ports. It writes data cells and an output register through those ports as well. The front end routes one 8-bit value to a two-digit, active-low seven-segment display. A select input picks either the output register or the data cell named by a 5-bit switch field. The front end also makes the clear and pointer-hold controls for the core. Holding the button down empties the data store and the output register in either mode. Leaving run mode holds the pointers at zero and keeps the data store cleared, so that every run starts from a clean tape.

Opcode encoding used by the core: 000 move right, 001 move left, 010 increment, 011 decrement, 100 loop open, 101 loop close, 110 output, 111 halt.

Top module: `tape_front_end`

## Requirements
- R1: In entry mode (run_mode=0), each press of btn_n (high to low) writes op_sw into the command word at addr_sw exactly once. The input passes a two-flop synchronizer, so holding the button or changing op_sw while it is held causes no second write.
- R2: In entry mode, led_o shows the command word stored at addr_sw. In run mode, led_o is 000.
- R3: run_led_o and core_hold_o follow the mode: run_led_o is 1 only in run mode, and core_hold_o is 1 only in entry mode.
- R4: While the synchronized button is held in run mode, every data cell and the output register read as zero, and core_clear_o is 1.
- R5: In entry mode, the data cells and the output register are held at zero and core writes to them are ignored.
- R6: In run mode, view_sel=0 shows the output register and view_sel=1 shows the data cell at cell_sw. In entry mode the shown value is 00.
- R7: seg_o[13:7] encodes the high nibble and seg_o[6:0] the low nibble, with bits g..a, active low (0 = 1000000, 5 = 0010010, F = 0001110). A code with no defined pattern lights only the middle segment.
- R8: core_op_o returns the command word at core_pc_i. A button press in run mode leaves the command store unchanged.
- R9: A core running the stored program "+++>++<[->+<]>." followed by halt leaves 05 on the display with view_sel=0, and 05 in data cell 1.
- R10: After rst_n the command store reads zero and the display shows 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 0 = program entry, 1 = execution |
| addr_sw | input | 6 | Command address in entry mode |
| op_sw | input | 3 | Opcode to store in entry mode |
| btn_n | input | 1 | Active-low write / clear button |
| view_sel | input | 1 | Display source: 0 output register, 1 data cell |
| cell_sw | input | 5 | Data cell shown when view_sel=1 |
| led_o | output | 3 | Stored opcode at addr_sw (entry mode) |
| run_led_o | output | 1 | High in run mode |
| seg_o | output | 14 | Two active-low seven-segment digits |
| core_pc_i | input | 6 | Core command read address |
| core_op_o | output | 3 | Command word at core_pc_i |
| core_dp_i | input | 5 | Core data address (read and write) |
| core_rdata_o | output | 8 | Data cell at core_dp_i |
| core_we_i | input | 1 | Core data cell write enable |
| core_wdata_i | input | 8 | Core data cell write value |
| core_out_we_i | input | 1 | Core output register load |
| core_out_data_i | input | 8 | Core output register value |
| core_clear_o | output | 1 | Data store is being cleared |
| core_hold_o | output | 1 | Core must hold its pointers at zero |

## Verification
Some properties are checked on every cycle. The press detector never fires on two cycles in a row. A command write lands at the latched address. The command store does not change without a write strobe. The data store and the output register are empty one cycle after any clear. Other behaviour can only be shown by bench scenarios. These include the LED readback, the display routing for both select values, the full nibble-to-segment mapping, and the result of a whole interpreted program running against the stored commands.

// File: rtl/fe_pkg.sv
package fe_pkg;

   typedef enum logic [2:0] {
      OP_RIGHT = 3'b000,
      OP_LEFT  = 3'b001,
      OP_INC   = 3'b010,
      OP_DEC   = 3'b011,
      OP_OPEN  = 3'b100,
      OP_CLOSE = 3'b101,
      OP_EMIT  = 3'b110,
      OP_HALT  = 3'b111
   } op_e;

   localparam logic [6:0] SEG_DASH = 7'b0111111;

   // active-low segments, bit order g f e d c b a
   function automatic logic [6:0] nib_to_seg(input logic [3:0] n);
      logic [6:0] s;
      case (n)
         4'h0: s = 7'b1000000;
         4'h1: s = 7'b1111001;
         4'h2: s = 7'b0100100;
         4'h3: s = 7'b0110000;
         4'h4: s = 7'b0011001;
         4'h5: s = 7'b0010010;
         4'h6: s = 7'b0000010;
         4'h7: s = 7'b1111000;
         4'h8: s = 7'b0000000;
         4'h9: s = 7'b0010000;
         4'hA: s = 7'b0001000;
         4'hB: s = 7'b0000011;
         4'hC: s = 7'b1000110;
         4'hD: s = 7'b0100001;
         4'hE: s = 7'b0000110;
         4'hF: s = 7'b0001110;
         default: s = SEG_DASH;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fe_press_sync.sv
module fe_press_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n,
   output logic held_o,
   output logic press_o
);
   if (STAGES < 2) begin : g_bad
      $error("fe_press_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              held_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q  <= '1;
         held_d_q <= 1'b0;
      end else begin
         chain_q  <= {chain_q[STAGES-2:0], btn_n};
         held_d_q <= held_o;
      end
   end

   assign held_o  = ~chain_q[STAGES-1];
   assign press_o = held_o & ~held_d_q;

   p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      press_o |=> !press_o);

endmodule

// File: rtl/fe_cmd_store.sv
module fe_cmd_store #(
   parameter int AW = 6,
   parameter int DW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_a_addr,
   output logic [DW-1:0] rd_a_data,
   input  logic [AW-1:0] rd_b_addr,
   output logic [DW-1:0] rd_b_data
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || DW < 1) begin : g_bad
      $error("fe_cmd_store: AW and DW must be positive");
   end

   logic [DW-1:0]       mem_q [DEPTH];
   logic [DEPTH*DW-1:0] flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_a_data = mem_q[rd_a_addr];
   assign rd_b_data = mem_q[rd_b_addr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign flat[g*DW +: DW] = mem_q[g];
   end

   p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

   p_store_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(flat));

endmodule

// File: rtl/fe_cell_store.sv
module fe_cell_store #(
   parameter int AW = 5,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_a_addr,
   output logic [DW-1:0] rd_a_data,
   input  logic [AW-1:0] rd_b_addr,
   output logic [DW-1:0] rd_b_data
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || DW < 1) begin : g_bad
      $error("fe_cell_store: AW and DW must be positive");
   end

   logic [DW-1:0] cell_q [DEPTH];
   logic          any_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
      end else if (clear) begin
         for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
      end else if (wr_en) begin
         cell_q[wr_addr] <= wr_data;
      end
   end

   assign rd_a_data = cell_q[rd_a_addr];
   assign rd_b_data = cell_q[rd_b_addr];

   always_comb begin
      any_set = 1'b0;
      for (int i = 0; i < DEPTH; i++) any_set = any_set | (|cell_q[i]);
   end

   p_cells_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !any_set);

endmodule

// File: rtl/fe_hex_disp.sv
module fe_hex_disp
   import fe_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0]       val,
   output logic [(DW/4)*7-1:0] seg
);
   localparam int DIGITS = DW / 4;

   if (DW % 4 != 0 || DW < 4) begin : g_bad
      $error("fe_hex_disp: DW must be a positive multiple of 4");
   end

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      assign seg[d*7 +: 7] = nib_to_seg(val[d*4 +: 4]);
   end

endmodule

// File: rtl/tape_front_end.sv
module tape_front_end #(
   parameter int CMD_AW      = 6,
   parameter int OP_W        = 3,
   parameter int DATA_AW     = 5,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_mode,
   input  logic [CMD_AW-1:0]       addr_sw,
   input  logic [OP_W-1:0]         op_sw,
   input  logic                    btn_n,
   input  logic                    view_sel,
   input  logic [DATA_AW-1:0]      cell_sw,
   output logic [OP_W-1:0]         led_o,
   output logic                    run_led_o,
   output logic [(DATA_W/4)*7-1:0] seg_o,
   input  logic [CMD_AW-1:0]       core_pc_i,
   output logic [OP_W-1:0]         core_op_o,
   input  logic [DATA_AW-1:0]      core_dp_i,
   output logic [DATA_W-1:0]       core_rdata_o,
   input  logic                    core_we_i,
   input  logic [DATA_W-1:0]       core_wdata_i,
   input  logic                    core_out_we_i,
   input  logic [DATA_W-1:0]       core_out_data_i,
   output logic                    core_clear_o,
   output logic                    core_hold_o
);
   if (OP_W != 3) begin : g_bad_op
      $error("tape_front_end: opcode width must be 3 for eight commands");
   end

   logic              btn_held, btn_press;
   logic              cmd_wr, clear_all;
   logic [OP_W-1:0]   led_word;
   logic [DATA_W-1:0] view_cell, out_q, shown;

   fe_press_sync #(.STAGES(SYNC_STAGES)) u_btn (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_n   (btn_n),
      .held_o  (btn_held),
      .press_o (btn_press)
   );

   assign cmd_wr    = btn_press & ~run_mode;
   assign clear_all = ~run_mode | btn_held;

   fe_cmd_store #(.AW(CMD_AW), .DW(OP_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cmd_wr),
      .wr_addr   (addr_sw),
      .wr_data   (op_sw),
      .rd_a_addr (addr_sw),
      .rd_a_data (led_word),
      .rd_b_addr (core_pc_i),
      .rd_b_data (core_op_o)
   );

   fe_cell_store #(.AW(DATA_AW), .DW(DATA_W)) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear_all),
      .wr_en     (core_we_i),
      .wr_addr   (core_dp_i),
      .wr_data   (core_wdata_i),
      .rd_a_addr (cell_sw),
      .rd_a_data (view_cell),
      .rd_b_addr (core_dp_i),
      .rd_b_data (core_rdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             out_q <= '0;
      else if (clear_all)     out_q <= '0;
      else if (core_out_we_i) out_q <= core_out_data_i;
   end

   always_comb begin
      if (!run_mode)     shown = '0;
      else if (view_sel) shown = view_cell;
      else               shown = out_q;
   end

   fe_hex_disp #(.DW(DATA_W)) u_hex (
      .val (shown),
      .seg (seg_o)
   );

   assign led_o        = run_mode ? '0 : led_word;
   assign run_led_o    = run_mode;
   assign core_hold_o  = ~run_mode;
   assign core_clear_o = clear_all;

   p_out_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> out_q == '0);

endmodule

// File: tb/tape_front_end_test.sv
module tape_front_end_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_mode = 1'b0;
   logic [5:0]  addr_sw = '0;
   logic [2:0]  op_sw = '0;
   logic        btn_n = 1'b1;
   logic        view_sel = 1'b0;
   logic [4:0]  cell_sw = '0;
   logic [2:0]  led_o;
   logic        run_led_o;
   logic [13:0] seg_o;
   logic [5:0]  core_pc_i = '0;
   logic [2:0]  core_op_o;
   logic [4:0]  core_dp_i = '0;
   logic [7:0]  core_rdata_o;
   logic        core_we_i = 1'b0;
   logic [7:0]  core_wdata_i = '0;
   logic        core_out_we_i = 1'b0;
   logic [7:0]  core_out_data_i = '0;
   logic        core_clear_o, core_hold_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   tape_front_end uut (.*);

   localparam logic [8:0] WR_TAB [6] = '{
      {6'd0, 3'd5}, {6'd1, 3'd2}, {6'd63, 3'd7},
      {6'd17, 3'd4}, {6'd42, 3'd1}, {6'd0, 3'd6}
   };
   localparam string PROG = "+++>++<[->+<]>.";

   function automatic logic [6:0] seg_ref(input logic [3:0] n);
      case (n)
         4'h0: return 7'b1000000; 4'h1: return 7'b1111001;
         4'h2: return 7'b0100100; 4'h3: return 7'b0110000;
         4'h4: return 7'b0011001; 4'h5: return 7'b0010010;
         4'h6: return 7'b0000010; 4'h7: return 7'b1111000;
         4'h8: return 7'b0000000; 4'h9: return 7'b0010000;
         4'hA: return 7'b0001000; 4'hB: return 7'b0000011;
         4'hC: return 7'b1000110; 4'hD: return 7'b0100001;
         4'hE: return 7'b0000110; default: return 7'b0001110;
      endcase
   endfunction

   function automatic logic [13:0] show(input logic [7:0] v);
      return {seg_ref(v[7:4]), seg_ref(v[3:0])};
   endfunction

   function automatic logic [2:0] enc(input byte c);
      case (c)
         ">": return 3'b000; "<": return 3'b001; "+": return 3'b010;
         "-": return 3'b011; "[": return 3'b100; "]": return 3'b101;
         ".": return 3'b110; default: return 3'b111;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic press();
      btn_n = 1'b0;
      repeat (5) @(posedge clk);
      btn_n = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put_cell(input logic [4:0] a, input logic [7:0] v);
      @(negedge clk);
      core_dp_i = a; core_wdata_i = v; core_we_i = 1'b1;
      @(negedge clk);
      core_we_i = 1'b0;
   endtask

   task automatic rd_op(input int a, output logic [2:0] o);
      core_pc_i = a[5:0];
      #1 o = core_op_o;
   endtask

   // bench model of the execution core (R9)
   task automatic run_prog();
      int pc = 0;
      int dp = 0;
      int depth;
      logic [2:0] op, o2;
      logic [7:0] v;
      for (int step = 0; step < 2000; step++) begin
         @(negedge clk);
         core_dp_i = dp[4:0];
         rd_op(pc, op);
         v = core_rdata_o;
         if (op == 3'b111) break;
         case (op)
            3'b000: dp++;
            3'b001: dp--;
            3'b010: put_cell(dp[4:0], v + 8'd1);
            3'b011: put_cell(dp[4:0], v - 8'd1);
            3'b110: begin
               @(negedge clk);
               core_out_data_i = v; core_out_we_i = 1'b1;
               @(negedge clk);
               core_out_we_i = 1'b0;
            end
            3'b100: if (v == 8'd0) begin
               depth = 1;
               while (depth > 0) begin
                  pc++; rd_op(pc, o2);
                  if (o2 == 3'b100) depth++;
                  if (o2 == 3'b101) depth--;
               end
            end
            3'b101: if (v != 8'd0) begin
               depth = 1;
               while (depth > 0) begin
                  pc--; rd_op(pc, o2);
                  if (o2 == 3'b101) depth++;
                  if (o2 == 3'b100) depth--;
               end
            end
            default: ;
         endcase
         pc++;
      end
   endtask

   initial begin
      #400000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [2:0] o;
      logic [2:0] ref_mem [64];
      for (int i = 0; i < 64; i++) ref_mem[i] = 3'b000;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state, R3 entry flags
      addr_sw = 6'd5;
      #1 chk("R10 led after reset", led_o, 3'b000);
      chk("R10 display after reset", seg_o, show(8'h00));
      chk("R3 run_led entry", run_led_o, 1'b0);
      chk("R3 hold entry", core_hold_o, 1'b1);

      // R1/R2 write table
      for (int i = 0; i < 6; i++) begin
         addr_sw = WR_TAB[i][8:3]; op_sw = WR_TAB[i][2:0];
         press();
         ref_mem[WR_TAB[i][8:3]] = WR_TAB[i][2:0];
         #1 chk("R1 R2 led readback", led_o, WR_TAB[i][2:0]);
      end
      for (int i = 0; i < 6; i++) begin
         addr_sw = WR_TAB[i][8:3];
         #1 chk("R2 led revisit", led_o, ref_mem[WR_TAB[i][8:3]]);
      end

      // R1 single write while held
      addr_sw = 6'd9; op_sw = 3'd3;
      btn_n = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk) op_sw = 3'd6;
      repeat (5) @(posedge clk);
      btn_n = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 one write per press", led_o, 3'd3);

      // R5 core writes ignored in entry mode
      put_cell(5'd2, 8'h77);
      #1 chk("R5 entry write ignored rdata", core_rdata_o, 8'h00);

      // load program
      for (int i = 0; i < 16; i++) begin
         addr_sw = i[5:0];
         op_sw = (i < PROG.len()) ? enc(PROG[i]) : 3'b111;
         press();
      end

      @(negedge clk) run_mode = 1'b1;
      addr_sw = 6'd0;
      #1 chk("R2 led dark in run", led_o, 3'b000);
      chk("R3 run_led run", run_led_o, 1'b1);
      chk("R3 hold run", core_hold_o, 1'b0);
      core_dp_i = 5'd2;
      #1 chk("R5 cell 2 still clear", core_rdata_o, 8'h00);
      rd_op(3, o);
      chk("R8 core read port", o, 3'b000);

      run_prog();
      @(negedge clk) view_sel = 1'b0;
      #1 chk("R9 output shows 05", seg_o, show(8'h05));
      view_sel = 1'b1; cell_sw = 5'd1;
      #1 chk("R9 R6 cell 1 shows 05", seg_o, show(8'h05));
      cell_sw = 5'd0;
      #1 chk("R6 cell 0 shows 00", seg_o, show(8'h00));

      // R4 clear in run mode; R8 no command write
      addr_sw = 6'd0; op_sw = 3'd7;
      btn_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R4 clear strobe", core_clear_o, 1'b1);
      btn_n = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      view_sel = 1'b0;
      #1 chk("R4 output reg cleared", seg_o, show(8'h00));
      view_sel = 1'b1; cell_sw = 5'd1;
      #1 chk("R4 cell cleared", seg_o, show(8'h00));
      rd_op(0, o);
      chk("R8 command kept after run press", o, 3'b010);

      // R7 full nibble map
      for (int i = 0; i < 8; i++) begin
         logic [7:0] v;
         v = {i[2:0], 1'b0, i[2:0], 1'b1} ^ 8'h00;
         v = {4'(2*i), 4'(2*i+1)};
         put_cell(i[4:0], v);
         cell_sw = i[4:0];
         #1 chk("R7 segment pattern", seg_o, show(v));
      end

      // R6 entry shows 00; R5 leaving run clears cells
      @(negedge clk) run_mode = 1'b0;
      @(negedge clk);
      #1 chk("R6 entry display 00", seg_o, show(8'h00));
      @(negedge clk) run_mode = 1'b1;
      core_dp_i = 5'd3;
      #1 chk("R5 cells cleared by entry", core_rdata_o, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule